// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two predictors side by side. The first is indexed by a 12-bit record of recent branch outcomes across the whole program. The second is a two-level predictor: it first looks up a 10-bit outcome history kept for each branch, then uses that history to index a table of 3-bit counters. A table of 2-bit selector counters, indexed by the global record, decides which of the two guesses is used. The default tables hold 4096 + 4096 two-bit counters, 1024 ten-bit histories and 1024 three-bit counters, about 29K bits in all.

The fetch side presents the word address bits of a branch and reads back the prediction in the same cycle. It also reads back the global and local histories used for that prediction, and keeps them with the branch. When the branch resolves, the back end presents the same address, the actual outcome and those saved histories. The block then trains every table at the supplied indices and shifts the outcome into both histories. Because training uses the saved histories and not the live ones, branches still in flight train the entries they were predicted from.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every prediction is not-taken (0), the global history reads 0, and every local history reads 0.
- R2: On an update, the global history becomes the supplied global history shifted left by one, with the outcome (1 = taken) in bit 0. The new value appears on `pred_ghist` in the following cycle.
- R3: The local history entry is selected by address bits [11:2] of the branch. Addresses that differ only above bit 11 share an entry. On an update, that entry becomes the supplied local history shifted left by one, with the outcome in bit 0.
- R4: The global predictor has one 2-bit counter per global history value. The counter at the supplied global history counts up on taken and down on not-taken, and saturates at 0 and 3. A value of 2 or 3 predicts taken.
- R5: The local predictor has one 3-bit counter per local history value. The counter at the supplied local history counts up on taken and down on not-taken, and saturates at 0 and 7. A value of 4 or more predicts taken.
- R6: The selector has one 2-bit counter per global history value. A value of 2 or 3 picks the global guess, and 0 or 1 picks the local guess. The counter changes only when the two guesses at the supplied indices disagree. It counts up when the global guess was right and down when the local guess was right, saturating at 0 and 3.
- R7: Reset sets every 2-bit counter to 1 and every 3-bit counter to 3. The prediction is a combinational function of the current address and the current state.
- R8: A cycle with `upd_valid` low changes no state, whatever the other update inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | LIDX_W (10) | Address bits [11:2] of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ghist | output | GH_W (12) | Global history used for this prediction |
| pred_lhist | output | LH_W (10) | Local history used for this prediction |
| upd_valid | input | 1 | Apply a training update this cycle |
| upd_pc | input | LIDX_W (10) | Address bits [11:2] of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_ghist | input | GH_W (12) | Global history saved at prediction time |
| upd_lhist | input | LH_W (10) | Local history saved at prediction time |

## Verification
The bench drives a short loop branch, always-taken and never-taken branches, and an alternating branch long enough to push counters into both saturation limits. A design whose counters wrap instead of clamping would soon flip its guess on a strongly biased branch. The selector is driven both through runs where the two guesses agree and through runs where they disagree. A design that trains the selector on agreement, or moves it the wrong way, would choose the weaker predictor for the loop branch. Local history aliasing is probed with two addresses that share index bits, to catch an index built from the wrong bits. Idle cycles with active-looking update data check that a missing valid gate does not corrupt state.

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int GH_W   = 12,
  parameter int LH_W   = 10,
  parameter int LIDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIDX_W-1:0] pred_pc,
  output logic              pred_taken,
  output logic [GH_W-1:0]   pred_ghist,
  output logic [LH_W-1:0]   pred_lhist,
  input  logic              upd_valid,
  input  logic [LIDX_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [GH_W-1:0]   upd_ghist,
  input  logic [LH_W-1:0]   upd_lhist
);
  localparam int GN = 1 << GH_W;
  localparam int LN = 1 << LIDX_W;
  localparam int CN = 1 << LH_W;

  logic [1:0]      gctr    [GN];
  logic [1:0]      chooser [GN];
  logic [2:0]      lctr    [CN];
  logic [LH_W-1:0] lhist   [LN];
  logic [GH_W-1:0] ghist_q;

  logic gp, lp;
  assign pred_ghist = ghist_q;
  assign pred_lhist = lhist[pred_pc];
  assign gp         = gctr[ghist_q][1];
  assign lp         = lctr[pred_lhist][2];
  assign pred_taken = chooser[ghist_q][1] ? gp : lp;

  logic [1:0] ug, uc, g_nx, c_nx;
  logic [2:0] ul, l_nx;
  logic       ugp, ulp;
  assign ug  = gctr[upd_ghist];
  assign uc  = chooser[upd_ghist];
  assign ul  = lctr[upd_lhist];
  assign ugp = ug[1];
  assign ulp = ul[2];

  always_comb begin
    if (upd_taken) g_nx = (ug == 2'd3) ? ug : ug + 2'd1;
    else           g_nx = (ug == 2'd0) ? ug : ug - 2'd1;
    if (upd_taken) l_nx = (ul == 3'd7) ? ul : ul + 3'd1;
    else           l_nx = (ul == 3'd0) ? ul : ul - 3'd1;
    c_nx = uc;
    if (ugp != ulp) begin
      if (ugp == upd_taken) c_nx = (uc == 2'd3) ? uc : uc + 2'd1;
      else                  c_nx = (uc == 2'd0) ? uc : uc - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghist_q <= '0;
      for (int i = 0; i < GN; i++) begin
        gctr[i]    <= 2'd1;
        chooser[i] <= 2'd1;
      end
      for (int i = 0; i < CN; i++) lctr[i]  <= 3'd3;
      for (int i = 0; i < LN; i++) lhist[i] <= '0;
    end else if (upd_valid) begin
      ghist_q            <= {upd_ghist[GH_W-2:0], upd_taken};
      lhist[upd_pc]      <= {upd_lhist[LH_W-2:0], upd_taken};
      gctr[upd_ghist]    <= g_nx;
      lctr[upd_lhist]    <= l_nx;
      chooser[upd_ghist] <= c_nx;
    end
  end

  a_r2_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist_q == {$past(upd_ghist[GH_W-2:0]), $past(upd_taken)});

  a_r8_ghist_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist_q));

  a_r3_lhist_write: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> lhist[$past(upd_pc)] == {$past(upd_lhist[LH_W-2:0]), $past(upd_taken)});

  a_r6_chooser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && ugp == ulp) |=> chooser[$past(upd_ghist)] == $past(uc));

  a_r4_gctr_up: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=> gctr[$past(upd_ghist)] >= $past(ug));

  a_r5_lctr_down: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> lctr[$past(upd_lhist)] <= $past(ul));
endmodule

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;
  localparam int GH_W = 12, LH_W = 10, LIDX_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LIDX_W-1:0] pred_pc = '0, upd_pc = '0;
  logic [GH_W-1:0]   upd_ghist = '0;
  logic [LH_W-1:0]   upd_lhist = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic pred_taken;
  logic [GH_W-1:0] pred_ghist;
  logic [LH_W-1:0] pred_lhist;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tournament_predictor #(.GH_W(GH_W), .LH_W(LH_W), .LIDX_W(LIDX_W)) uut (
    .clk, .rst_n, .pred_pc, .pred_taken, .pred_ghist, .pred_lhist,
    .upd_valid, .upd_pc, .upd_taken, .upd_ghist, .upd_lhist);

  // reference model built from the requirements
  int m_g [1<<GH_W];
  int m_c [1<<GH_W];
  int m_l [1<<LH_W];
  int m_lh[1<<LIDX_W];
  int m_gh;

  task automatic model_reset();
    for (int i = 0; i < (1<<GH_W); i++) begin m_g[i] = 1; m_c[i] = 1; end
    for (int i = 0; i < (1<<LH_W); i++) m_l[i] = 3;
    for (int i = 0; i < (1<<LIDX_W); i++) m_lh[i] = 0;
    m_gh = 0;
  endtask

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int pc, bit taken, string req);
    int eg, el, ep, gpv, lpv;
    @(negedge clk);
    pred_pc = pc[LIDX_W-1:0];
    #1;
    eg  = m_gh;
    el  = m_lh[pc];
    gpv = (m_g[eg] >= 2) ? 1 : 0;
    lpv = (m_l[el] >= 4) ? 1 : 0;
    ep  = (m_c[eg] >= 2) ? gpv : lpv;
    chk({req, " R2 ghist"}, int'(pred_ghist), eg);
    chk({req, " R3 lhist"}, int'(pred_lhist), el);
    chk({req, " R7 pred"},  int'(pred_taken), ep);
    upd_valid = 1'b1; upd_pc = pc[LIDX_W-1:0]; upd_taken = taken;
    upd_ghist = eg[GH_W-1:0]; upd_lhist = el[LH_W-1:0];
    // R4, R5, R6 model training
    if (gpv != lpv) begin
      if (gpv == int'(taken)) m_c[eg] = (m_c[eg] < 3) ? m_c[eg] + 1 : 3;
      else                    m_c[eg] = (m_c[eg] > 0) ? m_c[eg] - 1 : 0;
    end
    if (taken) begin
      if (m_g[eg] < 3) m_g[eg]++;
      if (m_l[el] < 7) m_l[el]++;
    end else begin
      if (m_g[eg] > 0) m_g[eg]--;
      if (m_l[el] > 0) m_l[el]--;
    end
    m_gh = ((eg << 1) | int'(taken)) & ((1<<GH_W)-1);
    m_lh[pc] = ((el << 1) | int'(taken)) & ((1<<LH_W)-1);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // {index[9:0], outcome}
  localparam logic [10:0] VEC [24] = '{
    {10'h080,1'b1},{10'h080,1'b1},{10'h080,1'b1},{10'h080,1'b0},
    {10'h090,1'b1},{10'h0A0,1'b0},{10'h090,1'b1},{10'h0A0,1'b0},
    {10'h080,1'b1},{10'h080,1'b1},{10'h080,1'b1},{10'h080,1'b0},
    {10'h0B0,1'b1},{10'h0B0,1'b0},{10'h0B0,1'b1},{10'h0B0,1'b0},
    {10'h3FF,1'b1},{10'h000,1'b0},{10'h3FF,1'b1},{10'h000,1'b0},
    {10'h080,1'b1},{10'h080,1'b1},{10'h080,1'b1},{10'h080,1'b0}
  };

  initial begin : watchdog
    #(5ns * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    #12 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); pred_pc = 10'h040; #1;
    chk("R1 pred", int'(pred_taken), 0);
    chk("R1 ghist", int'(pred_ghist), 0);
    chk("R1 lhist", int'(pred_lhist), 0);
    // first update: index 0x040 taken, histories 0
    step(10'h040, 1'b1, "first");
    @(negedge clk); pred_pc = 10'h040; #1;
    chk("R2 ghist after taken", int'(pred_ghist), 1);
    chk("R3 lhist own entry", int'(pred_lhist), 1);
    chk("R7 pred weak counters", int'(pred_taken), 0);
    pred_pc = 10'h041; #1;
    chk("R3 lhist other entry", int'(pred_lhist), 0);
    // R3 alias: byte address 0x1100 maps to word index 0x040 after dropping bit 12
    pred_pc = 10'((32'h1100 >> 2) & 32'h3FF); #1;
    chk("R3 lhist alias", int'(pred_lhist), 1);
    // R8 idle cycles with noisy update data
    @(negedge clk);
    upd_pc = 10'h040; upd_taken = 1'b0; upd_ghist = 12'hFFF; upd_lhist = 10'h3FF;
    repeat (3) @(negedge clk);
    pred_pc = 10'h040; #1;
    chk("R8 ghist unchanged", int'(pred_ghist), 1);
    chk("R8 lhist unchanged", int'(pred_lhist), 1);
    chk("R8 pred unchanged", int'(pred_taken), 0);
    // vector table
    for (int k = 0; k < 24; k++) step(int'(VEC[k][10:1]), VEC[k][0], "vec");
    // R4 R5 saturation: long biased runs
    for (int k = 0; k < 20; k++) step(10'h100, 1'b1, "R4 sat taken");
    for (int k = 0; k < 20; k++) step(10'h104, 1'b0, "R5 sat nt");
    // R6 loop branch pattern, learns through local history
    for (int k = 0; k < 400; k++) step(10'h080, (k % 4) != 3, "R6 loop");
    // mixed: loop interleaved with alternating branch
    for (int k = 0; k < 300; k++) begin
      step(10'h200, (k % 4) != 3, "R6 mixed loop");
      step(10'h204, k[0], "R5 mixed alt");
    end
    // R1 reset again mid-run
    @(negedge clk); rst_n = 1'b0; #1; model_reset();
    chk("R1 pred in reset", int'(pred_taken), 0);
    chk("R1 ghist in reset", int'(pred_ghist), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 8; k++) step(10'h080, 1'b1, "R1 after reset");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule